// File: doc/BRIEF.md
# Dense Matrix-Vector Engine

The engine computes y = A·x for an n-row, m-column integer matrix. A job begins with a start pulse that captures the row and column counts. The same input stream then carries two payloads back to back. First come the m elements of x, which the engine keeps in a local flop store. Then come the n·m elements of A in row-major order. Each matrix element is multiplied by the stored x entry for its column and added into the running sum for its row.

Each row's sum is kept as four interleaved partial sums. Column j feeds lane j mod 4, so the adder loop never has to finish within the arrival interval of consecutive elements. When the last element of a row arrives, the four lanes pass through a pairwise adder tree. The result is placed in an output register as one y value, and rows leave in order. A done pulse marks the end of the job.

Top module: `mvx_engine`

## Requirements
- R1: While reset is asserted and after its release, in_ready, out_valid and done are low until a start pulse arrives.
- R2: A start pulse while idle captures cfg_rows (n, at least 1) and cfg_cols (m, 1 to 1024). The next m accepted input words are stored as x[0] to x[m-1], in that order.
- R3: After x, the next n·m accepted words are a[i][j] in row-major order. Output word i is the sum over j of a[i][j]·x[j], using 16-bit signed inputs and a 40-bit two's-complement result that wraps without saturation. Rows are emitted in order 0 to n-1.
- R4: When m is not a multiple of four, including m = 1, the unused lanes of a row contribute zero and the result still follows R3.
- R5: If out_ready stays high, in_ready stays high on every cycle from the cycle after start until the last matrix word is accepted. The switch from the x phase to the matrix phase inserts no idle cycle.
- R6: While out_valid is high and out_ready is low, out_data stays stable and out_valid stays high. No y value is lost or duplicated under any backpressure pattern.
- R7: done is a single-cycle pulse in the cycle after the last y value is accepted. When done is high, in_ready and out_valid are low.
- R8: A start pulse during a job is ignored, and so is in_valid while idle. in_ready is low when idle.
- R9: Every job reloads x, so values from an earlier job never leak into a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job start pulse, sampled while idle |
| cfg_rows | input | 16 | Row count n |
| cfg_cols | input | 11 | Column count m |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when both are high |
| in_data | input | 16 | Signed x element or matrix element |
| out_valid | output | 1 | y value available |
| out_ready | input | 1 | Consumer accepts the y value |
| out_data | output | 40 | Signed y value |
| done | output | 1 | Job completion pulse |

## Verification
A lane that adds into the wrong slot, or misses its clear at a row boundary, shows up in the very next y value. An x entry written to the wrong address corrupts every row that reads that column. A column or row counter that slips by one shifts the row boundaries, so the first affected y value differs and the total count of outputs or the done cycle moves. Each y value and every done cycle is checked against a model driven by the port traffic, so a bad internal state is reported no later than the y value of the row it affects.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_MAT   = 2'd2,
    PH_FLUSH = 2'd3
  } mvx_phase_e;
endpackage

// File: rtl/mvx_xstore.sv
module mvx_xstore #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/mvx_seq.sv
module mvx_seq
  import mvx_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic             in_valid,
  input  logic             acc_stall,
  input  logic             out_fire,
  output logic             in_ready,
  output logic             x_we,
  output logic             mat_fire,
  output logic [COL_W-1:0] col,
  output logic             row_end,
  output logic             done
);
  mvx_phase_e       phase_q, phase_d;
  logic [ROW_W-1:0] rlast_q, rlast_d, row_q, row_d, orow_q, orow_d;
  logic [COL_W-1:0] clast_q, clast_d, col_q, col_d;
  logic             done_q, done_d;
  logic             accept, col_end;

  assign in_ready = (phase_q == PH_LOAD) || ((phase_q == PH_MAT) && !acc_stall);
  assign accept   = in_valid && in_ready;
  assign x_we     = accept && (phase_q == PH_LOAD);
  assign mat_fire = accept && (phase_q == PH_MAT);
  assign col_end  = (col_q == clast_q);
  assign col      = col_q;
  assign row_end  = col_end;
  assign done     = done_q;

  always_comb begin
    phase_d = phase_q;
    rlast_d = rlast_q;
    clast_d = clast_q;
    row_d   = row_q;
    col_d   = col_q;
    orow_d  = orow_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        rlast_d = cfg_rows - ROW_W'(1);
        clast_d = cfg_cols - COL_W'(1);
        row_d   = '0;
        col_d   = '0;
        orow_d  = '0;
        phase_d = PH_LOAD;
      end
      PH_LOAD: if (accept) begin
        col_d = col_end ? '0 : col_q + COL_W'(1);
        if (col_end) phase_d = PH_MAT;
      end
      PH_MAT: if (accept) begin
        col_d = col_end ? '0 : col_q + COL_W'(1);
        if (col_end) begin
          row_d = row_q + ROW_W'(1);
          if (row_q == rlast_q) phase_d = PH_FLUSH;
        end
      end
      PH_FLUSH: ;
      default: phase_d = PH_IDLE;
    endcase
    if (out_fire) begin
      orow_d = orow_q + ROW_W'(1);
      if (orow_q == rlast_q) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rlast_q <= '0;
      clast_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
      orow_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rlast_q <= rlast_d;
      clast_q <= clast_d;
      row_q   <= row_d;
      col_q   <= col_d;
      orow_q  <= orow_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/mvx_rowacc.sv
module mvx_rowacc #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int LANES = 4,
  localparam int SW   = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mat_fire,
  input  logic [DW-1:0]    a_in,
  input  logic [DW-1:0]    x_in,
  input  logic [SW-1:0]    slot_in,
  input  logic             last_in,
  input  logic             out_ready,
  output logic             acc_stall,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;
  logic                 p_valid_q, p_valid_d, p_last_q;
  logic [SW-1:0]        p_slot_q;
  logic [ACC_W-1:0]     p_prod_q;
  logic [ACC_W-1:0]     psum_q [LANES];
  logic [ACC_W-1:0]     psum_d [LANES];
  logic [ACC_W-1:0]     lane_add [LANES];
  logic [ACC_W-1:0]     tree [LANES];
  logic                 advance, emit, out_valid_q, out_valid_d;
  logic [ACC_W-1:0]     out_data_q;

  assign prod     = $signed(a_in) * $signed(x_in);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  assign acc_stall = p_valid_q && p_last_q && out_valid_q && !out_ready;
  assign advance   = p_valid_q && !acc_stall;
  assign emit      = advance && p_last_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_add[l] = psum_q[l] + ((p_slot_q == SW'(l)) ? p_prod_q : '0);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) tree[i] = lane_add[i];
    for (int s = 1; s < LANES; s = s * 2)
      for (int i = 0; i + s < LANES; i = i + 2 * s)
        tree[i] = tree[i] + tree[i + s];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      psum_d[l] = psum_q[l];
      if (advance) psum_d[l] = p_last_q ? '0 : lane_add[l];
    end
    p_valid_d   = mat_fire || (p_valid_q && acc_stall);
    out_valid_d = emit || (out_valid_q && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid_q   <= 1'b0;
      out_valid_q <= 1'b0;
      for (int l = 0; l < LANES; l++) psum_q[l] <= '0;
    end else begin
      p_valid_q   <= p_valid_d;
      out_valid_q <= out_valid_d;
      for (int l = 0; l < LANES; l++) psum_q[l] <= psum_d[l];
    end
  end

  always_ff @(posedge clk) begin
    if (mat_fire) begin
      p_prod_q <= prod_ext;
      p_slot_q <= slot_in;
      p_last_q <= last_in;
    end
    if (emit) out_data_q <= tree[0];
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/mvx_engine.sv
module mvx_engine #(
  parameter int ROW_W  = 16,
  parameter int XDEPTH = 1024,
  parameter int DW     = 16,
  parameter int ACC_W  = 40,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(XDEPTH),
  localparam int COL_W = AW + 1,
  localparam int SW    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             done
);
  logic             x_we, mat_fire, row_end, acc_stall, out_fire;
  logic [COL_W-1:0] col;
  logic [DW-1:0]    x_rd;

  assign out_fire = out_valid && out_ready;

  mvx_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
    .cfg_cols(cfg_cols), .in_valid(in_valid), .acc_stall(acc_stall),
    .out_fire(out_fire), .in_ready(in_ready), .x_we(x_we),
    .mat_fire(mat_fire), .col(col), .row_end(row_end), .done(done)
  );

  mvx_xstore #(.DEPTH(XDEPTH), .DW(DW)) u_xstore (
    .clk(clk), .we(x_we), .waddr(col[AW-1:0]), .wdata(in_data),
    .raddr(col[AW-1:0]), .rdata(x_rd)
  );

  mvx_rowacc #(.DW(DW), .ACC_W(ACC_W), .LANES(LANES)) u_rowacc (
    .clk(clk), .rst_n(rst_n), .mat_fire(mat_fire), .a_in(in_data),
    .x_in(x_rd), .slot_in(col[SW-1:0]), .last_in(row_end),
    .out_ready(out_ready), .acc_stall(acc_stall), .out_valid(out_valid),
    .out_data(out_data)
  );
endmodule

// File: rtl/mvx_engine_chk.sv
module mvx_engine_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic             done
);
  // R6: a stalled output keeps its value
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done follows an accepted y value
  p_done_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  // R7: engine is idle when done is raised
  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid));
endmodule

bind mvx_engine mvx_engine_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/mvx_engine_bench.sv
module mvx_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 40;

  logic        clk, rst_n, start, in_valid, in_ready, out_valid, out_ready, done;
  logic [15:0] cfg_rows, in_data;
  logic [10:0] cfg_cols;
  logic [ACC_W-1:0] out_data;

  int checks = 0, errors = 0, cycles = 0;
  int xv [0:1023];
  int av [0:4095];
  logic [15:0]      in_q [$];
  logic [ACC_W-1:0] exp_q [$];

  mvx_engine u_mvx_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
    .cfg_cols(cfg_cols), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      summary();
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s16();
    logic [15:0] r = 16'($urandom);
    return int'($signed(r));
  endfunction

  task automatic run_job(int n, int m, int vpct, int rpct, int bad_at, string req);
    int  bubbles = 0, outs = 0;
    bit  done_exp = 0, finished = 0;
    for (int j = 0; j < m; j++) in_q.push_back(16'(xv[j]));
    for (int k = 0; k < n * m; k++) in_q.push_back(16'(av[k]));
    for (int i = 0; i < n; i++) begin
      longint s = 0;
      for (int j = 0; j < m; j++) s += longint'(av[i*m+j]) * longint'(xv[j]);
      exp_q.push_back(ACC_W'(s));
    end
    @(negedge clk);
    start = 1'b1; cfg_rows = 16'(n); cfg_cols = 11'(m);
    in_valid = 1'b0; out_ready = 1'b0;
    #1 check(!in_ready, "R8 idle in_ready", longint'(in_ready), 0);
    for (int cyc = 0; cyc < 20000 && !finished; cyc++) begin
      @(negedge clk);
      start = (cyc == bad_at);
      if (cyc == bad_at) begin cfg_rows = 16'd1; cfg_cols = 11'd1; end
      in_valid  = (in_q.size() > 0) && ($urandom_range(99) < vpct);
      in_data   = (in_q.size() > 0) ? in_q[0] : 16'h0;
      out_ready = ($urandom_range(99) < rpct);
      #1;
      if (done_exp) begin
        check(done == 1'b1, "R7 done pulse", longint'(done), 1);
        check(!in_ready && !out_valid, "R7 idle at done",
              longint'({in_ready, out_valid}), 0);
        finished = 1;
      end else if (done) begin
        check(0, "R7 early done", 1, 0);
      end
      done_exp = 0;
      if (in_valid && in_ready) void'(in_q.pop_front());
      else if (vpct == 100 && rpct == 100 && in_q.size() > 0 && !in_ready) bubbles++;
      if (out_valid && out_ready) begin
        logic [ACC_W-1:0] e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        check(out_data == e, req, longint'($signed(out_data)), longint'($signed(e)));
        outs++;
        if (outs == n) done_exp = 1;
      end
    end
    start = 1'b0; in_valid = 1'b0;
    check(finished && outs == n, "R6 output count", outs, n);
    if (vpct == 100 && rpct == 100) check(bubbles == 0, "R5 bubbles", bubbles, 0);
    in_q.delete(); exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_rows = '0; cfg_cols = '0; in_data = '0;
    #(CLK_PERIOD*2 + 2);
    check(!in_ready && !out_valid && !done, "R1 reset", longint'({in_ready, out_valid, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    // R8: input ignored while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'h1234; out_ready = 1'b1;
      #1 check(!in_ready && !out_valid && !done, "R8 idle input", longint'({in_ready, out_valid, done}), 0);
    end
    in_valid = 1'b0;
    check(!in_ready && !out_valid, "R1 after release", longint'({in_ready, out_valid}), 0);

    // R2 R3: small fixed values
    for (int j = 0; j < 4; j++) xv[j] = j + 1;
    for (int k = 0; k < 12; k++) av[k] = k - 5;
    run_job(3, 4, 100, 100, -1, "R3 small");
    // R4: odd width
    for (int j = 0; j < 5; j++) xv[j] = s16();
    for (int k = 0; k < 10; k++) av[k] = s16();
    run_job(2, 5, 100, 100, -1, "R4 m=5");
    xv[0] = -7; av[0] = 9;
    run_job(1, 1, 100, 100, -1, "R4 m=1");
    // R6: random valid and ready
    for (int j = 0; j < 8; j++) xv[j] = s16();
    for (int k = 0; k < 32; k++) av[k] = s16();
    run_job(4, 8, 60, 30, -1, "R6 backpressure");
    // R3: large magnitudes beyond 32 bits
    for (int j = 0; j < 12; j++) xv[j] = -32768;
    for (int k = 0; k < 12; k++) begin av[k] = -32768; av[12+k] = 32767; end
    run_job(2, 12, 100, 100, -1, "R3 wide sum");
    // R8: start while busy
    for (int j = 0; j < 6; j++) xv[j] = s16();
    for (int k = 0; k < 18; k++) av[k] = s16();
    run_job(3, 6, 80, 50, 5, "R8 busy start");
    // R9: reload x with fresh values, same matrix as first job
    for (int j = 0; j < 4; j++) xv[j] = 100 - 37 * j;
    for (int k = 0; k < 12; k++) av[k] = k - 5;
    run_job(3, 4, 100, 100, -1, "R9 reload");
    // R5: sustained rate
    for (int j = 0; j < 16; j++) xv[j] = s16();
    for (int k = 0; k < 128; k++) av[k] = s16();
    run_job(8, 16, 100, 100, -1, "R5 rate");
    // R3: full depth, sum 2^40 wraps to zero
    for (int j = 0; j < 1024; j++) begin xv[j] = -32768; av[j] = -32768; end
    run_job(1, 1024, 100, 100, -1, "R3 wrap");
    summary();
  end
endmodule